// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This unit sits between a 32-bit register datapath and a data memory that is byte addressed but one word wide. For each request it computes the effective address from a base register and a signed 16-bit displacement, and it presents the memory with a word-aligned address. For a store it drives per-lane byte-enables and places the source data on the right lanes. For a load it takes the word the memory returns one cycle later, picks out the addressed byte or halfword, and widens it to 32 bits with sign or zero fill.

Lanes are little-endian. Address bits 1:0 select a byte lane and address bit 1 selects a halfword lane. A narrow store copies its data onto every lane of its size, so the byte-enables alone decide which bytes change. A halfword at an odd address, or a word that is not on a four-byte boundary, raises a misaligned flag, and the unit then issues no memory access. The memory is assumed to return read data on the clock edge after `mem_rd` is sampled.

Top module: `lsu_lane_align`

## Requirements
- R1: The effective address is `base_addr` plus `disp` sign-extended to 32 bits. `mem_addr` is that address with bits 1:0 forced to zero. A zero base therefore yields the displacement alone, and a zero displacement yields the base.
- R2: Access size codes on `req_size` are 0 = byte, 1 = halfword, 2 = word, and 3 acts as word. On a store, `mem_be` bit i enables byte lane i (bits 8i+7:8i). A byte store sets only bit (address mod 4). A halfword store sets 4'b0011 when address bit 1 is 0 and 4'b1100 when it is 1. A word store sets 4'b1111.
- R3: `mem_wdata` carries the low 8 source bits copied onto all four lanes for a byte store, the low 16 source bits copied onto both halves for a halfword store, and the whole source register for a word store.
- R4: `misaligned` is 1 during a valid request for a halfword with address bit 0 set, or for a word with address bits 1:0 nonzero. A misaligned request asserts neither `mem_wr` nor `mem_rd`, and it produces no `load_valid`.
- R5: When a valid aligned load is requested in cycle N, `load_valid` is 1 in cycle N+1. `load_data` then holds the addressed byte or halfword taken from `mem_rdata`, sign-extended when `req_unsigned` was 0 and zero-extended when it was 1.
- R6: A word load returns `mem_rdata` unchanged, whatever the value of `req_unsigned`.
- R7: While `rst` is high and in the cycle after it falls, `load_valid` is 0. With `req_valid` low, `misaligned`, `mem_wr`, `mem_rd` and `mem_be` are all 0.
- R8: `mem_wr` is 1 only for a valid aligned store, and `mem_rd` is 1 only for a valid aligned load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access size code (see R2) |
| req_unsigned | input | 1 | Zero-extend a narrow load |
| base_addr | input | 32 | Base register value |
| disp | input | 16 | Signed displacement |
| store_src | input | 32 | Source register for stores |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wr | output | 1 | Memory write strobe |
| mem_rd | output | 1 | Memory read strobe |
| mem_be | output | 4 | Per-lane write enables |
| mem_wdata | output | 32 | Lane-steered store data |
| mem_rdata | input | 32 | Word returned by memory, one cycle after `mem_rd` |
| misaligned | output | 1 | Current request breaks size alignment |
| load_valid | output | 1 | `load_data` is valid this cycle |
| load_data | output | 32 | Extracted and extended load result |

## Verification
Extraction of a load result from the previous cycle's request and steering of the current request happen in the same cycle. They must not disturb each other. The bench issues requests back to back, so each load's result is checked while the next request, often a store to the same word or a misaligned access, is being driven and checked. A behavioural memory in the bench and a shadow copy updated from the requirement rules decide whether each returned byte, halfword or word and each write strobe is correct.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned LANE_W = 8;
    localparam int unsigned LANES  = WORD_W / LANE_W;
    localparam int unsigned OFF_W  = $clog2(LANES);
    localparam int unsigned HALF_W = WORD_W / 2;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_HALF = 2'd1,
        ACC_WORD = 2'd2,
        ACC_WIDE = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic             vld;
        acc_size_e        size;
        logic             zext;
        logic [OFF_W-1:0] off;
    } ld_pend_t;

    function automatic logic is_word(acc_size_e s);
        return (s == ACC_WORD) || (s == ACC_WIDE);
    endfunction

    // True when the offset breaks the natural alignment of the size
    function automatic logic misfit(acc_size_e s, logic [OFF_W-1:0] off);
        logic r;
        case (s)
            ACC_BYTE: r = 1'b0;
            ACC_HALF: r = off[0];
            default:  r = (off != '0);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lsa_addr_gen.sv
module lsa_addr_gen
    import lsa_pkg::*;
#(
    parameter int unsigned DISP_W = 16
) (
    input  logic [WORD_W-1:0] base,
    input  logic [DISP_W-1:0] disp,
    output logic [WORD_W-1:0] word_addr,
    output logic [OFF_W-1:0]  off
);
    localparam int unsigned EXT_W = WORD_W - DISP_W;

    logic [WORD_W-1:0] disp_sx;
    logic [WORD_W-1:0] ea;

    always_comb begin
        disp_sx   = {{EXT_W{disp[DISP_W-1]}}, disp};
        ea        = base + disp_sx;
        off       = ea[OFF_W-1:0];
        word_addr = {ea[WORD_W-1:OFF_W], {OFF_W{1'b0}}};
    end
endmodule

// File: rtl/lsa_store_steer.sv
module lsa_store_steer
    import lsa_pkg::*;
(
    input  acc_size_e         size,
    input  logic [OFF_W-1:0]  off,
    input  logic [WORD_W-1:0] src,
    output logic [LANES-1:0]  be,
    output logic [WORD_W-1:0] wdata
);
    localparam int unsigned LANES_PER_HALF = LANES / 2;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam logic [OFF_W-1:0] LANE_ID = OFF_W'(g);
        localparam int unsigned      HSLOT   = g % LANES_PER_HALF;

        always_comb begin
            case (size)
                ACC_BYTE: begin
                    be[g]                     = (off == LANE_ID);
                    wdata[g*LANE_W +: LANE_W] = src[LANE_W-1:0];
                end
                ACC_HALF: begin
                    be[g]                     = (off[OFF_W-1] == LANE_ID[OFF_W-1]);
                    wdata[g*LANE_W +: LANE_W] = src[HSLOT*LANE_W +: LANE_W];
                end
                default: begin
                    be[g]                     = 1'b1;
                    wdata[g*LANE_W +: LANE_W] = src[g*LANE_W +: LANE_W];
                end
            endcase
        end
    end
endmodule

// File: rtl/lsa_load_extract.sv
module lsa_load_extract
    import lsa_pkg::*;
(
    input  ld_pend_t          pend,
    input  logic [WORD_W-1:0] rdata,
    output logic [WORD_W-1:0] data
);
    logic [LANE_W-1:0] sel_b;
    logic [HALF_W-1:0] sel_h;
    logic              fill_b;
    logic              fill_h;

    always_comb begin
        sel_b  = rdata[pend.off*LANE_W +: LANE_W];
        sel_h  = rdata[pend.off[OFF_W-1]*HALF_W +: HALF_W];
        fill_b = ~pend.zext & sel_b[LANE_W-1];
        fill_h = ~pend.zext & sel_h[HALF_W-1];
        data   = '0;
        if (pend.vld) begin
            case (pend.size)
                ACC_BYTE: data = {{(WORD_W-LANE_W){fill_b}}, sel_b};
                ACC_HALF: data = {{(WORD_W-HALF_W){fill_h}}, sel_h};
                default:  data = rdata;
            endcase
        end
    end
endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
    import lsa_pkg::*;
#(
    parameter int unsigned DISP_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_store,
    input  logic [1:0]        req_size,
    input  logic              req_unsigned,
    input  logic [31:0]       base_addr,
    input  logic [DISP_W-1:0] disp,
    input  logic [31:0]       store_src,
    output logic [31:0]       mem_addr,
    output logic              mem_wr,
    output logic              mem_rd,
    output logic [3:0]        mem_be,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              misaligned,
    output logic              load_valid,
    output logic [31:0]       load_data
);
    acc_size_e         size_q;
    logic [OFF_W-1:0]  off;
    logic [LANES-1:0]  be_raw;
    logic              bad_align;
    ld_pend_t          pend_q;

    assign size_q = acc_size_e'(req_size);

    lsa_addr_gen #(.DISP_W(DISP_W)) u_agen (
        .base      (base_addr),
        .disp      (disp),
        .word_addr (mem_addr),
        .off       (off)
    );

    lsa_store_steer u_steer (
        .size  (size_q),
        .off   (off),
        .src   (store_src),
        .be    (be_raw),
        .wdata (mem_wdata)
    );

    always_comb begin
        bad_align  = misfit(size_q, off);
        misaligned = req_valid & bad_align;
        mem_wr     = req_valid & req_store & ~bad_align;
        mem_rd     = req_valid & ~req_store & ~bad_align;
        mem_be     = mem_wr ? be_raw : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            pend_q.vld  <= mem_rd;
            pend_q.size <= size_q;
            pend_q.zext <= req_unsigned;
            pend_q.off  <= off;
        end
    end

    lsa_load_extract u_extr (
        .pend  (pend_q),
        .rdata (mem_rdata),
        .data  (load_data)
    );

    assign load_valid = pend_q.vld;
endmodule

// File: rtl/lsa_checker.sv
module lsa_checker (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_store,
    input logic [1:0]  req_size,
    input logic [31:0] mem_addr,
    input logic        mem_wr,
    input logic        mem_rd,
    input logic [3:0]  mem_be,
    input logic        misaligned,
    input logic        load_valid
);
    p_addr_aligned_r1: assert property (@(posedge clk) disable iff (rst)
        (mem_wr || mem_rd) |-> (mem_addr[1:0] == 2'b00));

    p_be_byte_r2: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && req_size == 2'd0) |-> ($countones(mem_be) == 1));

    p_be_half_r2: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && req_size == 2'd1) |-> (mem_be == 4'b0011 || mem_be == 4'b1100));

    p_be_word_r2: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && req_size[1]) |-> (mem_be == 4'b1111));

    p_mis_blocks_r4: assert property (@(posedge clk) disable iff (rst)
        misaligned |-> (!mem_wr && !mem_rd));

    p_load_next_r5: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> load_valid);

    p_no_stray_load_r5: assert property (@(posedge clk) disable iff (rst)
        !mem_rd |=> !load_valid);

    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> (!misaligned && mem_be == 4'b0000));

    p_strobe_kind_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_wr |-> (req_valid && req_store)) and (mem_rd |-> (req_valid && !req_store)));
endmodule

bind lsu_lane_align lsa_checker chk_i (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_store  (req_store),
    .req_size   (req_size),
    .mem_addr   (mem_addr),
    .mem_wr     (mem_wr),
    .mem_rd     (mem_rd),
    .mem_be     (mem_be),
    .misaligned (misaligned),
    .load_valid (load_valid)
);

// File: tb/lsu_lane_align_tb_top.sv
`timescale 1ns/1ps
module lsu_lane_align_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_store = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic        req_unsigned = 1'b0;
    logic [31:0] base_addr = '0;
    logic [15:0] disp = '0;
    logic [31:0] store_src = '0;
    logic [31:0] mem_addr;
    logic        mem_wr;
    logic        mem_rd;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        misaligned;
    logic        load_valid;
    logic [31:0] load_data;

    int n_chk  = 0;
    int n_fail = 0;

    logic [31:0] ram    [16];
    logic [31:0] shadow [16];
    logic        pend_ld = 1'b0;
    logic [31:0] pend_exp = '0;

    always #4 clk = ~clk;

    lsu_lane_align dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_store(req_store),
        .req_size(req_size), .req_unsigned(req_unsigned), .base_addr(base_addr),
        .disp(disp), .store_src(store_src), .mem_addr(mem_addr), .mem_wr(mem_wr),
        .mem_rd(mem_rd), .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .misaligned(misaligned), .load_valid(load_valid), .load_data(load_data)
    );

    // Behavioural word-wide memory with one-cycle read latency
    always @(posedge clk) begin
        if (mem_wr)
            for (int i = 0; i < 4; i++)
                if (mem_be[i]) ram[mem_addr[5:2]][8*i +: 8] <= mem_wdata[8*i +: 8];
        if (mem_rd) mem_rdata <= ram[mem_addr[5:2]];
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] x_be(input int sz, input int off);
        if (sz == 0) return 4'b0001 << off;
        if (sz == 1) return (off >= 2) ? 4'b1100 : 4'b0011;
        return 4'b1111;
    endfunction

    function automatic logic [31:0] x_wd(input int sz, input logic [31:0] s);
        if (sz == 0) return {s[7:0], s[7:0], s[7:0], s[7:0]};
        if (sz == 1) return {s[15:0], s[15:0]};
        return s;
    endfunction

    function automatic logic x_mis(input int sz, input int off);
        if (sz == 0) return 1'b0;
        if (sz == 1) return (off % 2) != 0;
        return off != 0;
    endfunction

    function automatic logic [31:0] x_ld(input int sz, input logic uns,
                                         input logic [31:0] w, input int off);
        logic [7:0]  b;
        logic [15:0] h;
        b = w[8*off +: 8];
        h = (off >= 2) ? w[31:16] : w[15:0];
        if (sz == 0) return uns ? {24'h0, b} : {{24{b[7]}}, b};
        if (sz == 1) return uns ? {16'h0, h} : {{16{h[15]}}, h};
        return w;
    endfunction

    // One request per cycle; the previous load result is judged in the same
    // cycle the new request is steered.
    task automatic step(input logic vld, input logic st, input logic [1:0] sz,
                        input logic uns, input logic [31:0] base,
                        input logic [15:0] dsp, input logic [31:0] src);
        logic [31:0] ea;
        int          off;
        int          szi;
        logic        mis;
        @(negedge clk);
        chk("R5", "load_valid", {31'b0, load_valid}, {31'b0, pend_ld});
        if (pend_ld) chk("R5/R6", "load_data", load_data, pend_exp);
        req_valid = vld; req_store = st; req_size = sz; req_unsigned = uns;
        base_addr = base; disp = dsp; store_src = src;
        #1;
        ea  = base + {{16{dsp[15]}}, dsp};
        off = int'(ea[1:0]);
        szi = (sz == 2'd3) ? 2 : int'(sz);
        mis = vld && x_mis(szi, off);
        chk("R4", "misaligned", {31'b0, misaligned}, {31'b0, mis});
        chk("R8", "mem_wr", {31'b0, mem_wr}, {31'b0, vld && st && !mis});
        chk("R8", "mem_rd", {31'b0, mem_rd}, {31'b0, vld && !st && !mis});
        if (vld) chk("R1", "mem_addr", mem_addr, {ea[31:2], 2'b00});
        if (vld && st && !mis) begin
            chk("R2", "mem_be", {28'b0, mem_be}, {28'b0, x_be(szi, off)});
            chk("R3", "mem_wdata", mem_wdata, x_wd(szi, src));
            for (int i = 0; i < 4; i++)
                if (x_be(szi, off) >= 0 && x_be(szi, off)[i])
                    shadow[ea[5:2]][8*i +: 8] = x_wd(szi, src)[8*i +: 8];
        end else begin
            chk("R7", "mem_be idle", {28'b0, mem_be}, 32'h0);
        end
        pend_ld  = vld && !st && !mis;
        pend_exp = x_ld(szi, uns, shadow[ea[5:2]], off);
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5EED_0042);
        for (int i = 0; i < 16; i++) begin
            ram[i] = '0;
            shadow[i] = '0;
        end
        repeat (3) @(negedge clk);
        chk("R7", "load_valid in reset", {31'b0, load_valid}, 32'h0);
        chk("R7", "misaligned in reset", {31'b0, misaligned}, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R7", "load_valid after reset", {31'b0, load_valid}, 32'h0);
        chk("R7", "mem_rd idle", {31'b0, mem_rd}, 32'h0);

        // Directed corners
        step(1, 1, 2'd2, 0, 32'h0, 16'h0010, 32'h80FF_7F80);   // R1 zero base, word store
        step(1, 0, 2'd0, 0, 32'h10, 16'h0000, '0);             // R1 zero disp, R5 byte 0x80 signed
        step(1, 0, 2'd0, 1, 32'h10, 16'h0000, '0);             // R5 unsigned byte
        step(1, 0, 2'd1, 0, 32'h12, 16'h0000, '0);             // R5 upper half 0x80FF signed
        step(1, 0, 2'd1, 1, 32'h14, 16'hFFFE, '0);             // R1 negative disp -> 0x12
        step(1, 0, 2'd2, 1, 32'h10, 16'h0000, '0);             // R6 word ignores unsigned
        step(1, 0, 2'd3, 0, 32'h10, 16'h0000, '0);             // R2/R6 code 3 acts as word
        for (int k = 0; k < 4; k++)                            // R2/R3 byte into each lane
            step(1, 1, 2'd0, 0, 32'h20 + k, 16'h0, 32'hAB00 + k);
        step(1, 0, 2'd2, 0, 32'h20, 16'h0, '0);
        step(1, 1, 2'd1, 0, 32'h22, 16'h0, 32'h1234_F00D);     // R2 upper half store
        step(1, 0, 2'd1, 0, 32'h21, 16'h0, '0);                // R4 odd half load
        step(1, 1, 2'd1, 0, 32'h23, 16'h0, 32'h1);             // R4 odd half store
        step(1, 1, 2'd2, 0, 32'h22, 16'h0, 32'h1);             // R4 word at offset 2
        step(1, 0, 2'd2, 0, 32'h20, 16'h0, '0);
        step(1, 1, 2'd0, 0, 32'h20, 16'h0, 32'h55);            // overlap: store beside load result
        step(1, 0, 2'd0, 0, 32'h20, 16'h0, '0);                // load right after store
        step(0, 1, 2'd2, 0, 32'h20, 16'h0, 32'hDEAD_BEEF);     // R7/R8 invalid store ignored
        step(1, 0, 2'd2, 0, 32'h20, 16'h0, '0);

        // Constrained random traffic
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] b;
            b = $urandom;
            step(($urandom % 8) != 0, $urandom % 2, 2'($urandom % 4), $urandom % 2,
                 b, 16'($urandom), $urandom);
        end
        step(0, 0, 2'd0, 0, '0, '0, '0);
        step(0, 0, 2'd0, 0, '0, '0, '0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule